// File: doc/BRIEF.md
# Control Register Target on a Two-Wire Serial Bus

This block lets a host controller program a bank of 8-bit control registers over an I2C bus and poll two live status flags. The system clock oversamples SCL and SDA. A START or STOP condition is recognised whenever SDA changes while SCL is high. The block answers to a fixed 7-bit device address.

After a write address, the first data byte is a subaddress. It holds a register index, an auto-increment flag and a test-enable flag. Every following byte is stored in the bank. After a read address there is no subaddress. The block streams a status byte that it rebuilds after every host acknowledge, until the host answers with a not-acknowledge.

The controller has ten states:
- ST_IDLE waits for START.
- ST_ADDR receives the address byte and moves to ST_ADDR_ACK on a match, or to ST_SKIP otherwise.
- ST_ADDR_ACK moves to ST_SUB for a write, or to ST_RDATA for a read.
- ST_SUB and ST_SUB_ACK take the subaddress, then move to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate for each data byte.
- ST_RDATA shifts the status byte out and moves to ST_RACK.
- ST_RACK returns to ST_RDATA on a host acknowledge, or moves to ST_SKIP on a not-acknowledge.
- ST_SKIP stays silent.

From any state, STOP returns the controller to ST_IDLE and START moves it to ST_ADDR.

Top module: `ctl_i2c_target`

## Requirements
- R1: After reset, register i holds ((29*i) mod 256) XOR 0x5A, and SDA is released (sda_oe = 0).
- R2: The device address is 7'b1000100, followed by the R/W bit (0 = write, 1 = read). A matching address is acknowledged. Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R3: The subaddress byte is acknowledged. Its bit 7 is the test flag, bit 6 is unused, bit 5 is auto-increment and bits 4..0 are the register index.
- R4: Each write data byte is acknowledged and stored at the current index. A register changes only when a data byte completes.
- R5: With auto-increment set, the index advances by one after each data byte, wrapping from 31 to 0.
- R6: With auto-increment clear, every data byte of the transaction goes to the same index.
- R7: Indices at or above NREG (24 by default) are acknowledged, but the byte is discarded.
- R8: A read returns a status byte MSB first: bit 0 = soft-mute active, bit 1 = 0 while soft-step is busy and 1 when idle, bits 7..2 = 0.
- R9: The status byte is captured again at the end of each host acknowledge. A host not-acknowledge ends the read, and the block then leaves SDA released until the next START.
- R10: For register index 20, bits 3..0 are written only when the test flag was set in the same access. Bits 7..4 are always written.
- R11: A START or STOP inside a byte aborts the transfer. The partial byte is discarded, and bytes completed earlier in the transaction keep their values.
- R12: The block changes its SDA drive only while SCL is low.
- R13: A repeated START, inside a byte or at a byte boundary, begins a new transaction with a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| mute_active_i | input | 1 | Soft-mute in progress |
| step_busy_i | input | 1 | Soft-step in progress |
| regs_o | output | NREG*8 | All register contents, register i at bits [8i+7:8i] |

## Verification
Two events meet in the read path: the status byte is captured in the same cycle that the SCL fall ending an acknowledge is seen, while the soft-mute and soft-step inputs may be changing at any time. The bench sets the inputs before the acknowledge and flips them in the middle of the byte being shifted out. It then expects that byte to carry the values captured at the acknowledge, and the next byte to carry the flipped values. A second meeting point is an abort that arrives after a completed byte. The bench places START or STOP a few bits into the following byte and expects the earlier byte to be kept and the partial one to be discarded.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

    localparam int DATA_W        = 8;
    localparam int IDX_W         = 5;
    localparam int SUB_TEST_BIT  = 7;
    localparam int SUB_AI_BIT    = 5;
    localparam int STAT_MUTE_BIT = 0;
    localparam int STAT_IDLE_BIT = 1;
    localparam logic [DATA_W-1:0] RESET_SEED = 8'h5A;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

    // Reset value of register idx: index scaled by 29, low byte, mixed with a seed.
    function automatic logic [DATA_W-1:0] reg_reset_value(input int unsigned idx);
        return DATA_W'(idx * 29) ^ RESET_SEED;
    endfunction

endpackage

// File: rtl/ctl_i2c_lines.sv
// Bus line sampler: synchronisers, SCL edges and START/STOP detection.
module ctl_i2c_lines #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic [SYNC_DEPTH-1:0] scl_pipe;
    logic [SYNC_DEPTH-1:0] sda_pipe;
    logic                  scl_prev;
    logic                  sda_prev;
    logic                  scl_s;
    logic                  sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_DEPTH-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_DEPTH-1];
            sda_prev <= sda_pipe[SYNC_DEPTH-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_DEPTH-1];
    assign sda_s     = sda_pipe[SYNC_DEPTH-1];
    assign sda_bit   = sda_s;
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/ctl_i2c_shift.sv
// Byte shifter shared by receive and transmit, with a bit counter.
module ctl_i2c_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic          shin_en,
    input  logic          shin_bit,
    input  logic          shout_en,
    output logic [DW-1:0] data_o,
    output logic          last_o
);
    localparam int CW = $clog2(DW);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt    <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load_en) begin
            data_o <= load_val;
            cnt    <= '0;
        end else if (shin_en) begin
            data_o <= {data_o[DW-2:0], shin_bit};
            cnt    <= cnt + 1'b1;
        end else if (shout_en) begin
            data_o <= {data_o[DW-2:0], 1'b0};
            cnt    <= cnt + 1'b1;
        end
    end

    assign last_o = (cnt == CW'(DW - 1));

endmodule

// File: rtl/ctl_i2c_regbank.sv
// Register bank with computed reset values and a test-gated bit group.
module ctl_i2c_regbank
    import ctl_i2c_pkg::*;
#(
    parameter int                NREG      = 24,
    parameter int                IW        = IDX_W,
    parameter int                DW        = DATA_W,
    parameter int                TEST_IDX  = 20,
    parameter logic [DW-1:0]     TEST_MASK = 8'h0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic               wr_test,
    output logic [NREG*DW-1:0] regs_o
);
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        // Bits that need the test flag of the same access.
        localparam logic [DW-1:0] GATED = (gi == TEST_IDX) ? TEST_MASK : '0;

        logic [DW-1:0] val;
        logic [DW-1:0] wmask;

        assign wmask = wr_test ? '1 : ~GATED;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val <= DW'(reg_reset_value(gi));
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                val <= (val & ~wmask) | (wr_data & wmask);
            end
        end

        assign regs_o[gi*DW +: DW] = val;
    end

endmodule

// File: rtl/ctl_i2c_target.sv
// Bus target: address match, subaddress decode, burst writes and status reads.
module ctl_i2c_target
    import ctl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h44,
    parameter int         NREG       = 24,
    parameter int         TEST_IDX   = 20,
    parameter logic [7:0] TEST_MASK  = 8'h0F,
    parameter int         SYNC_DEPTH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic                     mute_active_i,
    input  logic                     step_busy_i,
    output logic [NREG*DATA_W-1:0]   regs_o
);
    localparam int BANK_W = NREG * DATA_W;

    tgt_state_e        state;
    tgt_state_e        state_nx;

    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              sda_bit;

    logic [DATA_W-1:0] sh_data;
    logic              sh_last;
    logic              sh_in;
    logic              sh_out;
    logic              sh_load;

    logic              rx_state;
    logic              consume;
    logic              wr_en;
    logic              byte_rdy;
    logic              rw_q;
    logic              test_q;
    logic              ai_q;
    logic              nack_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] status_byte;

    ctl_i2c_lines #(
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    ctl_i2c_shift #(
        .DW (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_det),
        .load_en  (sh_load),
        .load_val (status_byte),
        .shin_en  (sh_in),
        .shin_bit (sda_bit),
        .shout_en (sh_out),
        .data_o   (sh_data),
        .last_o   (sh_last)
    );

    ctl_i2c_regbank #(
        .NREG      (NREG),
        .IW        (IDX_W),
        .DW        (DATA_W),
        .TEST_IDX  (TEST_IDX),
        .TEST_MASK (TEST_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (sh_data),
        .wr_test (test_q),
        .regs_o  (regs_o)
    );

    // Live status, captured into the shifter at the end of each acknowledge.
    always_comb begin
        status_byte                = '0;
        status_byte[STAT_MUTE_BIT] = mute_active_i;
        status_byte[STAT_IDLE_BIT] = ~step_busy_i;
    end

    assign rx_state = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);
    assign sh_in    = rx_state && scl_rise;
    assign consume  = rx_state && scl_fall && byte_rdy;
    assign wr_en    = (state == ST_WDATA) && consume;
    assign sh_load  = ((state == ST_ADDR_ACK) && scl_fall && rw_q)
                   || ((state == ST_RACK) && scl_fall && !nack_q);
    assign sh_out   = (state == ST_RDATA) && scl_fall && !sh_last;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (consume) begin
                        state_nx = (sh_data[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_SUB;
                end
                ST_SUB: begin
                    if (consume) state_nx = ST_SUB_ACK;
                end
                ST_SUB_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_WDATA: begin
                    if (consume) state_nx = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall && sh_last) state_nx = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall) state_nx = nack_q ? ST_SKIP : ST_RDATA;
                end
                ST_SKIP:      state_nx = ST_SKIP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Transaction context: byte-ready flag, direction, subaddress fields, host answer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_rdy <= 1'b0;
            rw_q     <= 1'b0;
            test_q   <= 1'b0;
            ai_q     <= 1'b0;
            nack_q   <= 1'b0;
            idx_q    <= '0;
        end else begin
            if (start_det || stop_det) begin
                byte_rdy <= 1'b0;
            end else if (sh_in && sh_last) begin
                byte_rdy <= 1'b1;
            end else if (consume) begin
                byte_rdy <= 1'b0;
            end

            if ((state == ST_ADDR) && consume) begin
                rw_q <= sh_data[0];
            end

            if ((state == ST_SUB) && consume) begin
                test_q <= sh_data[SUB_TEST_BIT];
                ai_q   <= sh_data[SUB_AI_BIT];
                idx_q  <= sh_data[IDX_W-1:0];
            end else if (wr_en && ai_q) begin
                idx_q <= idx_q + 1'b1;
            end

            if ((state == ST_RACK) && scl_rise) begin
                nack_q <= sda_bit;
            end
        end
    end

    // Outputs: the SDA pull-down.
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK,
            ST_SUB_ACK,
            ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:     sda_oe = ~sh_data[DATA_W-1];
            default:      sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctl_i2c_target_chk.sv
// Temporal checks for the bus target, bound to the top module.
module ctl_i2c_target_chk #(
    parameter int IW     = 5,
    parameter int BANK_W = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic              ai_q,
    input logic [IW-1:0]     idx_q,
    input logic [BANK_W-1:0] regs_o
);
    // R12: drive changes only while SCL is low, except after an abort condition.
    p_sda_edge_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

    // R4: the bank only moves on a completed data byte.
    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R5: auto-increment advances the index by one, wrapping.
    p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ai_q) |=> (idx_q == IW'($past(idx_q) + 1'b1)));

    // R6: without auto-increment the index is kept.
    p_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ai_q) |=> (idx_q == $past(idx_q)));

    // R9: STOP leaves the line released.
    p_release_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(
    .IW     (ctl_i2c_pkg::IDX_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wr_en     (wr_en),
    .ai_q      (ai_q),
    .idx_q     (idx_q),
    .regs_o    (regs_o)
);

// File: tb/ctl_i2c_target_bench.sv
module ctl_i2c_target_bench;

    localparam int         NREG = 24;
    localparam int         Q    = 16;
    localparam logic [6:0] DEV  = 7'b1000100;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_h = 1'b1;
    logic mute  = 1'b0;
    logic busy  = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    assign sda_line = sda_h & ~sda_oe;

    always #4 clk = ~clk;

    ctl_i2c_target u_ctl_i2c_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .mute_active_i (mute),
        .step_busy_i   (busy),
        .regs_o        (regs)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int r12_bad = 0;
    logic oe_prev = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    item_t      mon_e;
    logic [7:0] mon_act;

    function automatic logic [7:0] dflt(input int i);
        int p;
        p = (i * 29) % 256;
        return 8'(p) ^ 8'h5A;
    endfunction

    // Scoreboard monitor: pairs each observed result with the next expected item.
    always @(negedge clk) begin
        if (obs_q.size() > 0) begin
            mon_act = obs_q.pop_front();
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 scoreboard: unexpected result actual %02h expected none", mon_act);
            end else begin
                mon_e = exp_q.pop_front();
                if (mon_act !== mon_e.val) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", mon_e.tag, mon_act, mon_e.val);
                end
            end
        end
    end

    // R12 watcher: drive edges while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) r12_bad++;
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input string tag, input logic [7:0] v);
        exp_q.push_back('{tag, v});
    endtask

    task automatic observe(input logic [7:0] v);
        obs_q.push_back(v);
    endtask

    task automatic i2c_start();
        sda_h = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_h = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;    tick(Q);
        scl   = 1'b1; tick(2 * Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic take_bit(output logic b);
        sda_h = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, input string tag, input logic exp_ack);
        logic b;
        expect_item(tag, {7'b0, exp_ack});
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        take_bit(b);
        observe({7'b0, ~b});
    endtask

    task automatic get_byte(input string tag, input logic [7:0] exp_v, input logic host_ack,
                            input int flip_at, input logic new_mute, input logic new_busy);
        logic [7:0] d;
        logic b;
        expect_item(tag, exp_v);
        for (int i = 7; i >= 0; i--) begin
            if (i == flip_at) begin
                mute = new_mute;
                busy = new_busy;
            end
            take_bit(b);
            d[i] = b;
        end
        observe(d);
        put_bit(!host_ack);
    endtask

    task automatic check_reg(input string tag, input int idx, input logic [7:0] v);
        expect_item(tag, v);
        observe(regs[idx*8 +: 8]);
    endtask

    task automatic finish_run();
        tick(20);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 scoreboard: %0d expected items left, actual 0 expected %0d",
                     exp_q.size(), exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        tick(150000);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog: run did not end, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1: reset contents and released line
        expect_item("R1 sda released after reset", 8'h00);
        observe({7'b0, sda_oe});
        for (int i = 0; i < NREG; i++) check_reg("R1 reset value", i, dflt(i));

        // R2 R3 R4 R5: auto-increment burst from index 3
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h23, "R3 subaddress ack", 1'b1);
        put_byte(8'hA1, "R4 data ack", 1'b1);
        put_byte(8'hB2, "R4 data ack", 1'b1);
        put_byte(8'hC3, "R4 data ack", 1'b1);
        i2c_stop();
        check_reg("R4 first byte", 3, 8'hA1);
        check_reg("R5 second byte", 4, 8'hB2);
        check_reg("R5 third byte", 5, 8'hC3);
        check_reg("R5 beyond burst untouched", 6, dflt(6));

        // R6: fixed index
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h07, "R3 subaddress ack", 1'b1);
        put_byte(8'h11, "R6 data ack", 1'b1);
        put_byte(8'h22, "R6 data ack", 1'b1);
        put_byte(8'h33, "R6 data ack", 1'b1);
        i2c_stop();
        check_reg("R6 last byte kept", 7, 8'h33);
        check_reg("R6 next index untouched", 8, dflt(8));

        // R5 R7: wrap from 30 through 31 to 0
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h3E, "R3 subaddress ack", 1'b1);
        put_byte(8'h44, "R7 ack beyond bank", 1'b1);
        put_byte(8'h55, "R7 ack beyond bank", 1'b1);
        put_byte(8'h66, "R5 ack after wrap", 1'b1);
        i2c_stop();
        check_reg("R5 wrap to index 0", 0, 8'h66);
        check_reg("R7 top register untouched", 23, dflt(23));

        // R2: foreign address ignored
        i2c_start();
        put_byte({7'h45, 1'b0}, "R2 foreign address nack", 1'b0);
        put_byte(8'h02, "R2 no ack after mismatch", 1'b0);
        put_byte(8'hEE, "R2 no ack after mismatch", 1'b0);
        i2c_stop();
        check_reg("R2 register untouched", 2, dflt(2));

        // R10: test-gated bits of index 20
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h14, "R3 subaddress ack", 1'b1);
        put_byte(8'hFF, "R10 data ack", 1'b1);
        i2c_stop();
        check_reg("R10 low bits held without test flag", 20, (dflt(20) & 8'h0F) | 8'hF0);
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h94, "R3 subaddress ack", 1'b1);
        put_byte(8'h5A, "R10 data ack", 1'b1);
        i2c_stop();
        check_reg("R10 all bits with test flag", 20, 8'h5A);

        // R8 R9: status read, inputs flipped mid-byte
        mute = 1'b1;
        busy = 1'b0;
        i2c_start();
        put_byte({DEV, 1'b1}, "R2 read address ack", 1'b1);
        get_byte("R8 status mute and idle", 8'h03, 1'b1, 3, 1'b0, 1'b1);
        get_byte("R9 refreshed status", 8'h00, 1'b0, -1, 1'b0, 1'b1);
        tick(Q);
        expect_item("R9 released after nack", 8'h00);
        observe({7'b0, sda_oe});
        begin
            logic b;
            expect_item("R9 silent after nack", 8'h01);
            take_bit(b);
            observe({7'b0, b});
        end
        i2c_stop();
        busy = 1'b0;
        i2c_start();
        put_byte({DEV, 1'b1}, "R2 read address ack", 1'b1);
        get_byte("R8 status idle no mute", 8'h02, 1'b0, -1, 1'b0, 1'b0);
        i2c_stop();

        // R11: STOP inside a byte
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h29, "R3 subaddress ack", 1'b1);
        put_byte(8'h77, "R11 data ack", 1'b1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        i2c_stop();
        check_reg("R11 completed byte kept", 9, 8'h77);
        check_reg("R11 partial byte discarded", 10, dflt(10));

        // R11 R13: START inside a byte, then a new write
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h2B, "R3 subaddress ack", 1'b1);
        put_byte(8'h88, "R11 data ack", 1'b1);
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        i2c_start();
        put_byte({DEV, 1'b0}, "R13 address ack after restart", 1'b1);
        put_byte(8'h0D, "R13 subaddress ack", 1'b1);
        put_byte(8'h3C, "R13 data ack", 1'b1);
        i2c_stop();
        check_reg("R11 byte before restart kept", 11, 8'h88);
        check_reg("R11 partial before restart discarded", 12, dflt(12));
        check_reg("R13 write after restart", 13, 8'h3C);

        // R13: repeated START at a byte boundary switching to read
        i2c_start();
        put_byte({DEV, 1'b0}, "R2 address ack", 1'b1);
        put_byte(8'h0F, "R3 subaddress ack", 1'b1);
        put_byte(8'h99, "R4 data ack", 1'b1);
        mute = 1'b1;
        busy = 1'b1;
        i2c_start();
        put_byte({DEV, 1'b1}, "R13 read address ack", 1'b1);
        get_byte("R8 status mute and busy", 8'h01, 1'b0, -1, 1'b1, 1'b1);
        i2c_stop();
        check_reg("R13 write before restart", 15, 8'h99);

        // R12: edge watcher result
        expect_item("R12 sda edges while scl high", 8'h00);
        observe(8'(r12_bad));

        finish_run();
    end

endmodule